// File: doc/BRIEF.md
# Alarm-Compare Real-Time Counter

This peripheral keeps a free-running 32-bit time count driven from a slow tick-enable. A divider accepts the tick-enable, which arrives at 32768 Hz, and produces one count step every 2×(DIV+1) accepted ticks. With the usual DIV setting of 1023, the count advances sixteen times a second, so the low four bits hold sixteenths of a second and the whole-second value is the count shifted right by four. Software can load the count at any time, and the count rolls over from all-ones to zero.

Two compare registers watch the count. When an increment makes the count equal to one of them, a sticky flag sets in the status word. A third flag sets on every increment. Each flag has an enable bit in the same word, and the interrupt line is the OR of every flag that is enabled. Flags clear when software writes 1 to them. A scratch word holds whatever software stores there, for example an overflow epoch. The count runs only while the clock-select word holds 3.

The divider is a two-state machine. ST_HALT is the reset state: the divider phase is held at zero and nothing counts. The machine moves from ST_HALT to ST_RUN on the first clock after clock-select reads 3. It moves from ST_RUN back to ST_HALT on the first clock after clock-select holds any other value. In ST_RUN, each accepted tick advances the phase, and the tick that completes a period emits one step.

Top module: `rtc_alarm_counter`

## Requirements
- R1: After reset, every register reads 0 and irq is low. The register offsets are count 0x00, compare A 0x04, status 0x08, divider 0x0C, compare B 0x18, clock-select 0x1C and scratch 0x40.
- R2: The count does not advance while clock-select holds any value other than 3.
- R3: With clock-select at 3, the count increments once for every 2×(DIV+1) cycles in which tick_32k is high. A write to the count or to the divider restarts the period.
- R4: A software write to offset 0x00 loads the count. An increment from 0xFFFFFFFF gives 0.
- R5: Status bit 0 sets when an increment makes the count equal to compare A. A compare value of 0 never matches.
- R6: Status bit 4 sets when an increment makes the count equal to compare B. A compare value of 0 never matches.
- R7: Status bit 1 sets on every increment.
- R8: Writing 1 to status bit 0, 1 or 4 clears that flag, and writing 0 leaves it unchanged. A flag that sets in the same cycle as its clear stays set.
- R9: Status bits 2, 3 and 6 are read/write enables for the flags at bits 0, 1 and 4. irq is high exactly when some flag and its enable are both 1. The flags can be acknowledged and the enables cleared in one write.
- R10: The scratch word, both compare words, the divider and clock-select read back what was written. Reads at unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | 32768 Hz tick-enable, one cycle per tick |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read select, 0 otherwise |
| irq | output | 1 | OR of the enabled flags |

## Verification
Most internal faults show up in the count value. A divider phase that is off by one cycle, or that fails to reset on a restart, moves the step edge, so the count read after an exact number of ticks is wrong right away. The bench checks this at the period boundary for DIV=1023 and for random small dividers. A compare or flag fault shows in the status word and on irq in the cycle after the edge that made the count equal to the compare value. The same-cycle set-and-clear case and the wrap to zero are driven directly, because a wrong priority or a match on zero shows only there.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_COUNT   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_CMPA    = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_STAT    = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_DIV     = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_CMPB    = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_CSEL    = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_SCRATCH = 8'h40;

    // status word bit positions (decoded by software)
    localparam int SB_AF = 0;
    localparam int SB_TF = 1;
    localparam int SB_AE = 2;
    localparam int SB_TE = 3;
    localparam int SB_BF = 4;
    localparam int SB_BE = 6;

    localparam int CSEL_RUN = 3;

    typedef enum logic [0:0] {ST_HALT, ST_RUN} run_state_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_req_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             step_o
);
    localparam int LIM_W = DIV_W + 1;

    run_state_t        state_q, state_d;
    logic [LIM_W-1:0]  phase_q, phase_d;
    logic [LIM_W-1:0]  limit;

    assign limit = {div_i, 1'b1};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run_req_i)  state_d = ST_RUN;
            ST_RUN:  if (!run_req_i) state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    always_comb begin
        step_o  = 1'b0;
        phase_d = phase_q;
        unique case (state_q)
            ST_HALT: phase_d = '0;
            ST_RUN: begin
                if (tick_i) begin
                    if (phase_q >= limit) begin
                        phase_d = '0;
                        step_o  = 1'b1;
                    end else begin
                        phase_d = phase_q + LIM_W'(1);
                    end
                end
            end
        endcase
        if (restart_i) begin
            phase_d = '0;
            step_o  = 1'b0;
        end
    end

    // R2
    halt_nostep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> !step_o);
    // R3
    step_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> tick_i);
    // R3
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> (phase_q == '0));
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] cmpa_i,
    input  logic [CNT_W-1:0] cmpb_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             inc_o,
    output logic             hita_o,
    output logic             hitb_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;

    assign cnt_next = cnt_q + CNT_W'(1);
    assign inc_o    = step_i && !load_i;
    assign hita_o   = inc_o && (cmpa_i != '0) && (cnt_next == cmpa_i);
    assign hitb_o   = inc_o && (cmpb_i != '0) && (cnt_next == cmpb_i);
    assign cnt_o    = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (step_i) cnt_q <= cnt_next;
    end

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_o |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
    // R4
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i)));
    // R5
    cmpa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpa_i == '0) |-> !hita_o);
    // R6
    cmpb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpb_i == '0) |-> !hitb_o);
endmodule

// File: rtl/rtc_status.sv
module rtc_status
    import rtc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              clr_a_i,
    input  logic              clr_t_i,
    input  logic              clr_b_i,
    input  logic              en_a_i,
    input  logic              en_t_i,
    input  logic              en_b_i,
    input  logic              set_a_i,
    input  logic              set_t_i,
    input  logic              set_b_i,
    output logic [DATA_W-1:0] stat_o,
    output logic              irq_o
);
    logic af_q, tf_q, bf_q;
    logic ae_q, te_q, be_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            af_q <= 1'b0; tf_q <= 1'b0; bf_q <= 1'b0;
            ae_q <= 1'b0; te_q <= 1'b0; be_q <= 1'b0;
        end else begin
            if (set_a_i)              af_q <= 1'b1;
            else if (wr_i && clr_a_i) af_q <= 1'b0;
            if (set_t_i)              tf_q <= 1'b1;
            else if (wr_i && clr_t_i) tf_q <= 1'b0;
            if (set_b_i)              bf_q <= 1'b1;
            else if (wr_i && clr_b_i) bf_q <= 1'b0;
            if (wr_i) begin
                ae_q <= en_a_i;
                te_q <= en_t_i;
                be_q <= en_b_i;
            end
        end
    end

    always_comb begin
        stat_o        = '0;
        stat_o[SB_AF] = af_q;
        stat_o[SB_TF] = tf_q;
        stat_o[SB_AE] = ae_q;
        stat_o[SB_TE] = te_q;
        stat_o[SB_BF] = bf_q;
        stat_o[SB_BE] = be_q;
    end

    assign irq_o = (af_q && ae_q) || (tf_q && te_q) || (bf_q && be_q);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_a_i |=> af_q);
    // R8
    w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_a_i && !set_a_i) |=> (af_q == $past(af_q)));
    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (af_q || tf_q || bf_q));
endmodule

// File: rtl/rtc_alarm_counter.sv
module rtc_alarm_counter
    import rtc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16,
    parameter int CSEL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0] cmpa_q, cmpb_q, scratch_q;
    logic [DIV_W-1:0]  div_q;
    logic [CSEL_W-1:0] csel_q;

    logic wr_en;
    logic wr_count, wr_cmpa, wr_stat, wr_div, wr_cmpb, wr_csel, wr_scratch;
    logic step, inc, hita, hitb;
    logic [DATA_W-1:0] cnt, stat;

    assign wr_en      = bus_sel && bus_wr;
    assign wr_count   = wr_en && (bus_addr == OFF_COUNT);
    assign wr_cmpa    = wr_en && (bus_addr == OFF_CMPA);
    assign wr_stat    = wr_en && (bus_addr == OFF_STAT);
    assign wr_div     = wr_en && (bus_addr == OFF_DIV);
    assign wr_cmpb    = wr_en && (bus_addr == OFF_CMPB);
    assign wr_csel    = wr_en && (bus_addr == OFF_CSEL);
    assign wr_scratch = wr_en && (bus_addr == OFF_SCRATCH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpa_q    <= '0;
            cmpb_q    <= '0;
            scratch_q <= '0;
            div_q     <= '0;
            csel_q    <= '0;
        end else begin
            if (wr_cmpa)    cmpa_q    <= bus_wdata;
            if (wr_cmpb)    cmpb_q    <= bus_wdata;
            if (wr_scratch) scratch_q <= bus_wdata;
            if (wr_div)     div_q     <= bus_wdata[DIV_W-1:0];
            if (wr_csel)    csel_q    <= bus_wdata[CSEL_W-1:0];
        end
    end

    rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_32k),
        .run_req_i (csel_q == CSEL_W'(CSEL_RUN)),
        .restart_i (wr_count || wr_div),
        .div_i     (div_q),
        .step_o    (step)
    );

    rtc_count_core #(.CNT_W(DATA_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .load_i     (wr_count),
        .load_val_i (bus_wdata),
        .cmpa_i     (cmpa_q),
        .cmpb_i     (cmpb_q),
        .cnt_o      (cnt),
        .inc_o      (inc),
        .hita_o     (hita),
        .hitb_o     (hitb)
    );

    rtc_status #(.DATA_W(DATA_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_stat),
        .clr_a_i (bus_wdata[SB_AF]),
        .clr_t_i (bus_wdata[SB_TF]),
        .clr_b_i (bus_wdata[SB_BF]),
        .en_a_i  (bus_wdata[SB_AE]),
        .en_t_i  (bus_wdata[SB_TE]),
        .en_b_i  (bus_wdata[SB_BE]),
        .set_a_i (hita),
        .set_t_i (inc),
        .set_b_i (hitb),
        .stat_o  (stat),
        .irq_o   (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                OFF_COUNT:   bus_rdata = cnt;
                OFF_CMPA:    bus_rdata = cmpa_q;
                OFF_STAT:    bus_rdata = stat;
                OFF_DIV:     bus_rdata = DATA_W'(div_q);
                OFF_CMPB:    bus_rdata = cmpb_q;
                OFF_CSEL:    bus_rdata = DATA_W'(csel_q);
                OFF_SCRATCH: bus_rdata = scratch_q;
                default:     bus_rdata = '0;
            endcase
        end
    end

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> (bus_rdata == '0));
    // R5
    hit_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hita |=> stat[SB_AF]);
endmodule

// File: tb/rtc_alarm_counter_test.sv
module rtc_alarm_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bsel = 1'b0;
    logic        bwr = 1'b0;
    logic [7:0]  baddr = 8'h00;
    logic [31:0] bwdata = 32'h0;
    logic [31:0] rdata;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    rtc_alarm_counter uut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick),
        .bus_sel(bsel), .bus_wr(bwr), .bus_addr(baddr),
        .bus_wdata(bwdata), .bus_rdata(rdata), .irq(irq)
    );

    localparam logic [7:0] A_CNT = 8'h00, A_CA = 8'h04, A_ST = 8'h08, A_DIV = 8'h0C,
                           A_CB = 8'h18, A_CS = 8'h1C, A_SC = 8'h40;

    task automatic drive(input logic tk, input logic sel, input logic wr,
                         input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        tick = tk; bsel = sel; bwr = wr; baddr = a; bwdata = d;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        drive(1'b0, 1'b1, 1'b1, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 8'h00, 32'h0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 1'b0, 8'h00, 32'h0);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        drive(1'b0, 1'b1, 1'b0, a, 32'h0);
        #1 v = rdata;
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic check_irq(input string tag, input logic exp);
        drive(1'b0, 1'b0, 1'b0, 8'h00, 32'h0);
        #1 check(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    function automatic logic [31:0] exp_count(input logic [31:0] c, input int n, input int d);
        return c + 32'(n / (2 * (d + 1)));
    endfunction

    function automatic logic exp_hit(input logic [31:0] c, input int steps, input logic [31:0] a);
        if (a == 32'h0) return 1'b0;
        for (int i = 1; i <= steps; i++)
            if (c + 32'(i) == a) return 1'b1;
        return 1'b0;
    endfunction

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check_rd("R1 count", A_CNT, 32'h0);
        check_rd("R1 cmpA", A_CA, 32'h0);
        check_rd("R1 status", A_ST, 32'h0);
        check_rd("R1 div", A_DIV, 32'h0);
        check_rd("R1 cmpB", A_CB, 32'h0);
        check_rd("R1 csel", A_CS, 32'h0);
        check_rd("R1 scratch", A_SC, 32'h0);
        check_irq("R1 irq", 1'b0);

        // R2 halted while clock-select is not 3
        wr(A_CNT, 32'd5);
        ticks(10);
        check_rd("R2 halt csel=0", A_CNT, 32'd5);
        wr(A_CS, 32'd2);
        idle(2);
        ticks(10);
        check_rd("R2 halt csel=2", A_CNT, 32'd5);

        wr(A_CS, 32'd3);
        idle(2);

        // R10 readback and unmapped read
        wr(A_SC, 32'hDEADBEEF);
        check_rd("R10 scratch", A_SC, 32'hDEADBEEF);
        check_rd("R10 csel", A_CS, 32'd3);
        check_rd("R10 unmapped", 8'h20, 32'h0);

        // R3 boundary with DIV=1023
        wr(A_DIV, 32'd1023);
        check_rd("R10 div", A_DIV, 32'd1023);
        wr(A_CNT, 32'd100);
        ticks(2047);
        check_rd("R3 div1023 before", A_CNT, 32'd100);
        ticks(1);
        check_rd("R3 div1023 at period", A_CNT, 32'd101);

        // R4 wrap, R5 compare value zero never matches, R7 tick flag
        wr(A_DIV, 32'd0);
        wr(A_CA, 32'h0);
        wr(A_ST, 32'h0000_0008 | 32'h13);
        wr(A_CNT, 32'hFFFF_FFFF);
        ticks(2);
        check_rd("R4 wrap", A_CNT, 32'h0);
        check_rd("R5 zero cmp no match, R7 tick flag", A_ST, 32'h0000_000A);
        check_irq("R9 tick irq", 1'b1);

        // R5 compare A match, flag without enable gives no irq
        wr(A_ST, 32'h13);
        wr(A_CA, 32'h0000_1000);
        wr(A_CNT, 32'h0000_0FFF);
        ticks(2);
        check_rd("R5 cmpA flag", A_ST, 32'h0000_0003);
        check_irq("R9 no enable no irq", 1'b0);

        // R8 write 0 keeps flags, R9 enable makes irq
        wr(A_ST, 32'h0000_0004);
        check_rd("R8 w0 keeps", A_ST, 32'h0000_0007);
        check_irq("R9 cmpA irq", 1'b1);
        // R9 ack and disable in one write
        wr(A_ST, 32'h0000_0003);
        check_rd("R9 ack+disable", A_ST, 32'h0);
        check_irq("R9 irq low after ack", 1'b0);

        // R6 compare B
        wr(A_CB, 32'h0000_2000);
        check_rd("R10 cmpB", A_CB, 32'h0000_2000);
        wr(A_ST, 32'h0000_0040);
        wr(A_CNT, 32'h0000_1FFF);
        ticks(2);
        check_rd("R6 cmpB flag", A_ST, 32'h0000_0052);
        check_irq("R6 cmpB irq", 1'b1);
        wr(A_ST, 32'h0000_0052);
        check_rd("R8 clear B and tick", A_ST, 32'h0000_0040);
        check_irq("R8 irq low", 1'b0);

        // R8 set wins over same-cycle clear
        wr(A_ST, 32'h13);
        wr(A_CA, 32'h0000_3000);
        wr(A_CNT, 32'h0000_2FFF);
        ticks(1);
        drive(1'b1, 1'b1, 1'b1, A_ST, 32'h0000_0001);
        check_rd("R8 set wins", A_ST, 32'h0000_0003);
        check_rd("R4 count after set-wins", A_CNT, 32'h0000_3000);

        // R3/R5 constrained random
        for (int it = 0; it < 24; it++) begin
            int d, n, steps;
            logic [31:0] c, a;
            d = int'($urandom % 4);
            n = int'($urandom % 41);
            c = ($urandom % 4 == 0) ? (32'hFFFF_FFF0 + ($urandom % 16)) : $urandom;
            a = c + 32'd1 + ($urandom % 24);
            steps = n / (2 * (d + 1));
            wr(A_DIV, 32'(d));
            wr(A_CA, a);
            wr(A_ST, 32'h13);
            wr(A_CNT, c);
            ticks(n);
            check_rd("R3 random count", A_CNT, exp_count(c, n, d));
            rd(A_ST, v);
            check("R5 random cmpA flag", {31'b0, v[0]}, {31'b0, exp_hit(c, steps, a)});
        end

        idle(2);
        report();
    end
endmodule